// File: doc/BRIEF.md
# Byte Alignment Address and Data Unit

This unit lets software read a misaligned 8-byte quantity with two ordinary aligned loads. One operation, the address step, adds two 64-bit operands, hands back the sum rounded down to an 8-byte boundary, and keeps the discarded low three bits in a small internal offset register. A later operation, the data step, takes the two aligned words that were fetched. It treats them as one 16-byte string, with the first word at the most significant end, and returns the 8 bytes that begin at the stored byte offset.

A second flavour of the address step stores the two's-complement negation of the low three bits instead of the bits themselves. This suits little-endian byte ordering. The offset register is visible on an output port at all times. Each operation is accepted on a cycle where the valid strobe is high, and its result appears registered one clock later with a matching valid flag.

Top module: `byte_align_unit`

## Requirements
- R1: While reset is asserted, and after it is released, out_vld is 0, out_res is all zeros and out_ofs is 0. Reset is asynchronous on assertion and is released on a clock edge after a two-stage synchroniser.
- R2: out_vld is high in exactly the cycles that follow a clock edge at which in_vld was high. out_res keeps its value across any cycle in which in_vld was low.
- R3: With in_op = 0 (big-endian address step), out_res becomes (in_a + in_b) modulo 2^64 with bits [2:0] forced to zero.
- R4: With in_op = 0, out_ofs becomes bits [2:0] of (in_a + in_b) from the cycle after the operation.
- R5: With in_op = 1 (little-endian address step), out_res is the same rounded sum as in R3, and out_ofs becomes bits [2:0] of the negated sum, so that out_ofs + sum[2:0] is 0 modulo 8.
- R6: With in_op = 2 (data step), the 16-byte string {in_a, in_b} is indexed from byte 0 at its most significant end. out_res becomes bytes k through k+7 of that string, where k is the offset held before the operation.
- R7: A data step with an offset of 0 returns in_a unchanged.
- R8: A data step never changes the offset. A data step issued in the cycle right after an address step uses the offset that the address step wrote.
- R9: in_op = 3 is reserved: out_res becomes zero, out_vld still pulses and the offset is unchanged.
- R10: While in_vld is low, the offset does not change, whatever the values of in_op, in_a and in_b.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_vld | input | 1 | Operation strobe |
| in_op | input | 2 | Operation: 0 address step, 1 little-endian address step, 2 data step, 3 reserved |
| in_a | input | 64 | First operand, or the high-order word of a data step |
| in_b | input | 64 | Second operand, or the low-order word of a data step |
| out_vld | output | 1 | Result valid, one cycle after in_vld |
| out_res | output | 64 | Registered result |
| out_ofs | output | 3 | Current byte offset |

## Verification
The properties are checked against the raw reset port. They assume that in_vld stays low until the internal reset synchroniser has let go, two edges after rst_n rises. The stimulus therefore waits several idle cycles after each release before it issues an operation. The properties also assume that in_op and the operands are steady around each sampling edge. The stimulus changes inputs only on the falling clock edge, and it chains address and data steps back to back so that the offset hand-over between consecutive cycles is exercised.

// File: rtl/balign_pkg.sv
package balign_pkg;

  typedef enum logic [1:0] {
    OP_ADDR_BE = 2'd0,
    OP_ADDR_LE = 2'd1,
    OP_DATA    = 2'd2,
    OP_RSVD    = 2'd3
  } balign_op_e;

endpackage

// File: rtl/balign_rst_sync.sv
module balign_rst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n_async,
  output logic rst_n_sync
);

  logic [STAGES-1:0] sync_q;
  logic [STAGES-1:0] sync_d;

  always_comb begin
    sync_d = {sync_q[STAGES-2:0], 1'b1};
  end

  always_ff @(posedge clk or negedge rst_n_async) begin
    if (!rst_n_async) begin
      sync_q <= '0;
    end else begin
      sync_q <= sync_d;
    end
  end

  assign rst_n_sync = sync_q[STAGES-1];

endmodule

// File: rtl/balign_addr.sv
module balign_addr #(
  parameter int DATA_W = 64,
  parameter int OFS_W  = 3
) (
  input  logic [DATA_W-1:0] opnd_a,
  input  logic [DATA_W-1:0] opnd_b,
  output logic [DATA_W-1:0] rounded,
  output logic [OFS_W-1:0]  ofs_big,
  output logic [OFS_W-1:0]  ofs_little
);

  logic [DATA_W-1:0] sum;

  always_comb begin
    sum        = opnd_a + opnd_b;
    rounded    = {sum[DATA_W-1:OFS_W], {OFS_W{1'b0}}};
    ofs_big    = sum[OFS_W-1:0];
    ofs_little = (~sum[OFS_W-1:0]) + {{(OFS_W-1){1'b0}}, 1'b1};
  end

endmodule

// File: rtl/balign_funnel.sv
module balign_funnel #(
  parameter int DATA_W = 64,
  parameter int BYTE_W = 8,
  localparam int NBYTES = DATA_W / BYTE_W,
  localparam int OFS_W  = $clog2(NBYTES)
) (
  input  logic [DATA_W-1:0] word_hi,
  input  logic [DATA_W-1:0] word_lo,
  input  logic [OFS_W-1:0]  byte_sel,
  output logic [DATA_W-1:0] extract
);

  logic [2*DATA_W-1:0] pair;
  logic [DATA_W-1:0]   cand [NBYTES];

  assign pair = {word_hi, word_lo};

  // One candidate window per possible byte offset, counted from the top byte
  for (genvar k = 0; k < NBYTES; k++) begin : g_win
    assign cand[k] = pair[2*DATA_W-1-k*BYTE_W -: DATA_W];
  end

  assign extract = cand[byte_sel];

endmodule

// File: rtl/balign_ofs_reg.sv
module balign_ofs_reg #(
  parameter int OFS_W = 3
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr_en,
  input  logic [OFS_W-1:0] wr_val,
  output logic [OFS_W-1:0] ofs_q
);

  logic [OFS_W-1:0] ofs_d;

  always_comb begin
    ofs_d = ofs_q;
    if (wr_en) begin
      ofs_d = wr_val;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ofs_q <= '0;
    end else if (wr_en) begin
      ofs_q <= ofs_d;
    end
  end

endmodule

// File: rtl/byte_align_unit.sv
module byte_align_unit
  import balign_pkg::*;
#(
  parameter int DATA_W = 64,
  parameter int BYTE_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              in_vld,
  input  logic [1:0]        in_op,
  input  logic [DATA_W-1:0] in_a,
  input  logic [DATA_W-1:0] in_b,
  output logic              out_vld,
  output logic [DATA_W-1:0] out_res,
  output logic [$clog2(DATA_W/BYTE_W)-1:0] out_ofs
);

  localparam int NBYTES = DATA_W / BYTE_W;
  localparam int OFS_W  = $clog2(NBYTES);

  logic              rst_n_int;
  balign_op_e        op;
  logic [DATA_W-1:0] addr_rounded;
  logic [OFS_W-1:0]  ofs_big;
  logic [OFS_W-1:0]  ofs_little;
  logic [DATA_W-1:0] data_extract;
  logic [OFS_W-1:0]  ofs_cur;
  logic              ofs_we;
  logic [OFS_W-1:0]  ofs_wd;
  logic              vld_d;
  logic              vld_q;
  logic              res_en;
  logic [DATA_W-1:0] res_d;
  logic [DATA_W-1:0] res_q;

  assign op = balign_op_e'(in_op);

  balign_rst_sync #(.STAGES(2)) u_rst (
    .clk         (clk),
    .rst_n_async (rst_n),
    .rst_n_sync  (rst_n_int)
  );

  balign_addr #(.DATA_W(DATA_W), .OFS_W(OFS_W)) u_addr (
    .opnd_a     (in_a),
    .opnd_b     (in_b),
    .rounded    (addr_rounded),
    .ofs_big    (ofs_big),
    .ofs_little (ofs_little)
  );

  balign_funnel #(.DATA_W(DATA_W), .BYTE_W(BYTE_W)) u_funnel (
    .word_hi  (in_a),
    .word_lo  (in_b),
    .byte_sel (ofs_cur),
    .extract  (data_extract)
  );

  balign_ofs_reg #(.OFS_W(OFS_W)) u_ofs (
    .clk    (clk),
    .rst_n  (rst_n_int),
    .wr_en  (ofs_we),
    .wr_val (ofs_wd),
    .ofs_q  (ofs_cur)
  );

  // Next-state decode
  always_comb begin
    vld_d  = in_vld;
    res_en = in_vld;
    res_d  = res_q;
    ofs_we = 1'b0;
    ofs_wd = ofs_cur;
    if (in_vld) begin
      unique case (op)
        OP_ADDR_BE: begin
          res_d  = addr_rounded;
          ofs_we = 1'b1;
          ofs_wd = ofs_big;
        end
        OP_ADDR_LE: begin
          res_d  = addr_rounded;
          ofs_we = 1'b1;
          ofs_wd = ofs_little;
        end
        OP_DATA: begin
          res_d  = data_extract;
        end
        default: begin
          res_d  = '0;
        end
      endcase
    end
  end

  // Output registers
  always_ff @(posedge clk or negedge rst_n_int) begin
    if (!rst_n_int) begin
      vld_q <= 1'b0;
      res_q <= '0;
    end else begin
      vld_q <= vld_d;
      if (res_en) begin
        res_q <= res_d;
      end
    end
  end

  assign out_vld = vld_q;
  assign out_res = res_q;
  assign out_ofs = ofs_cur;

endmodule

// File: rtl/balign_chk.sv
module balign_chk #(
  parameter int DATA_W = 64,
  parameter int BYTE_W = 8,
  localparam int OFS_W = $clog2(DATA_W / BYTE_W)
) (
  input logic              clk,
  input logic              rst_n,
  input logic              in_vld,
  input logic [1:0]        in_op,
  input logic [DATA_W-1:0] in_a,
  input logic [DATA_W-1:0] in_b,
  input logic              out_vld,
  input logic [DATA_W-1:0] out_res,
  input logic [OFS_W-1:0]  out_ofs
);

  logic [OFS_W-1:0] low_sum;
  logic             is_addr;

  assign low_sum = in_a[OFS_W-1:0] + in_b[OFS_W-1:0];
  assign is_addr = in_vld && !in_op[1];

  assert_vld_rise_R2: assert property (@(posedge clk) disable iff (!rst_n)
    in_vld |=> out_vld);

  assert_vld_fall_R2: assert property (@(posedge clk) disable iff (!rst_n)
    !in_vld |=> !out_vld);

  assert_res_hold_R2: assert property (@(posedge clk) disable iff (!rst_n)
    !in_vld |=> $stable(out_res));

  assert_addr_aligned_R3: assert property (@(posedge clk) disable iff (!rst_n)
    is_addr |=> (out_res[OFS_W-1:0] == {OFS_W{1'b0}}));

  assert_ofs_big_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (in_vld && in_op == 2'd0) |=> (out_ofs == $past(low_sum)));

  assert_ofs_little_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (in_vld && in_op == 2'd1) |=> ((out_ofs + $past(low_sum)) == {OFS_W{1'b0}}));

  assert_zero_ofs_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (in_vld && in_op == 2'd2 && out_ofs == {OFS_W{1'b0}}) |=> (out_res == $past(in_a)));

  assert_ofs_kept_R8: assert property (@(posedge clk) disable iff (!rst_n)
    !is_addr |=> $stable(out_ofs));

  assert_rsvd_zero_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (in_vld && in_op == 2'd3) |=> (out_res == {DATA_W{1'b0}}));

endmodule

bind byte_align_unit balign_chk #(.DATA_W(DATA_W), .BYTE_W(BYTE_W)) u_chk (.*);

// File: tb/sim_byte_align_unit.sv
`timescale 1ns/1ps
module sim_byte_align_unit;

  typedef struct packed {
    logic [1:0]  op;
    logic [63:0] a;
    logic [63:0] b;
    logic [63:0] res;
    logic [2:0]  ofs;
  } vec_t;

  localparam int NVEC = 14;
  localparam vec_t VEC [NVEC] = '{
    '{2'd0, 64'h0000_0000_0000_1000, 64'h0000_0000_0000_0005, 64'h0000_0000_0000_1000, 3'd5}, // R3 R4
    '{2'd2, 64'h0011_2233_4455_6677, 64'h8899_AABB_CCDD_EEFF, 64'h5566_7788_99AA_BBCC, 3'd5}, // R6 R8
    '{2'd1, 64'h0000_0000_0000_1000, 64'h0000_0000_0000_0001, 64'h0000_0000_0000_1000, 3'd7}, // R5
    '{2'd2, 64'h0011_2233_4455_6677, 64'h8899_AABB_CCDD_EEFF, 64'h7788_99AA_BBCC_DDEE, 3'd7}, // R6
    '{2'd0, 64'hFFFF_FFFF_FFFF_FFFF, 64'h0000_0000_0000_0002, 64'h0000_0000_0000_0000, 3'd1}, // R3 wrap
    '{2'd2, 64'h0011_2233_4455_6677, 64'h8899_AABB_CCDD_EEFF, 64'h1122_3344_5566_7788, 3'd1}, // R6
    '{2'd1, 64'h0000_0000_0000_0008, 64'h0000_0000_0000_0000, 64'h0000_0000_0000_0008, 3'd0}, // R5
    '{2'd2, 64'h0011_2233_4455_6677, 64'h8899_AABB_CCDD_EEFF, 64'h0011_2233_4455_6677, 3'd0}, // R7
    '{2'd3, 64'h1234_5678_9ABC_DEF0, 64'h0FED_CBA9_8765_4321, 64'h0000_0000_0000_0000, 3'd0}, // R9
    '{2'd0, 64'h0123_4567_89AB_CDEF, 64'h0000_0000_0000_0010, 64'h0123_4567_89AB_CDF8, 3'd7}, // R3 R4
    '{2'd1, 64'h0000_0000_0000_0000, 64'h0000_0000_0000_0006, 64'h0000_0000_0000_0000, 3'd2}, // R5
    '{2'd2, 64'hA0A1_A2A3_A4A5_A6A7, 64'hB0B1_B2B3_B4B5_B6B7, 64'hA2A3_A4A5_A6A7_B0B1, 3'd2}, // R6
    '{2'd3, 64'hFFFF_FFFF_FFFF_FFFF, 64'hFFFF_FFFF_FFFF_FFFF, 64'h0000_0000_0000_0000, 3'd2}, // R9
    '{2'd2, 64'hA0A1_A2A3_A4A5_A6A7, 64'hB0B1_B2B3_B4B5_B6B7, 64'hA2A3_A4A5_A6A7_B0B1, 3'd2}  // R9 R8
  };

  logic        clk;
  logic        rst_n;
  logic        in_vld;
  logic [1:0]  in_op;
  logic [63:0] in_a;
  logic [63:0] in_b;
  logic        out_vld;
  logic [63:0] out_res;
  logic [2:0]  out_ofs;

  int n_chk;
  int n_fail;
  bit done;

  byte_align_unit u0 (
    .clk     (clk),
    .rst_n   (rst_n),
    .in_vld  (in_vld),
    .in_op   (in_op),
    .in_a    (in_a),
    .in_b    (in_b),
    .out_vld (out_vld),
    .out_res (out_res),
    .out_ofs (out_ofs)
  );

  initial clk = 1'b0;
  always #4 clk = ~clk;

  task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic summary();
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
  endtask

  initial begin
    #1600000;
    if (!done) begin
      n_chk++;
      n_fail++;
      $display("FAIL watchdog actual=hung expected=finished");
      summary();
      $finish;
    end
  end

  initial begin
    n_chk  = 0;
    n_fail = 0;
    done   = 1'b0;
    rst_n  = 1'b0;
    in_vld = 1'b0;
    in_op  = 2'd0;
    in_a   = '0;
    in_b   = '0;
    repeat (3) @(negedge clk);
    chk("R1 vld in reset", 64'(out_vld), 64'd0);
    chk("R1 res in reset", out_res, 64'd0);
    chk("R1 ofs in reset", 64'(out_ofs), 64'd0);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    chk("R1 ofs after release", 64'(out_ofs), 64'd0);
    chk("R1 vld after release", 64'(out_vld), 64'd0);

    // Table walk: one operation per cycle, back to back
    for (int i = 0; i < NVEC; i++) begin
      in_vld = 1'b1;
      in_op  = VEC[i].op;
      in_a   = VEC[i].a;
      in_b   = VEC[i].b;
      @(negedge clk);
      chk($sformatf("R2 vld vec %0d", i), 64'(out_vld), 64'd1);
      chk($sformatf("R3/R6 res vec %0d op %0d", i, VEC[i].op), out_res, VEC[i].res);
      chk($sformatf("R4/R5 ofs vec %0d op %0d", i, VEC[i].op), 64'(out_ofs), 64'(VEC[i].ofs));
    end

    // R10: idle address step must not touch offset; R2 result holds
    in_vld = 1'b0;
    in_op  = 2'd0;
    in_a   = 64'h0000_0000_0000_0005;
    in_b   = 64'h0;
    @(negedge clk);
    chk("R10 ofs with vld low", 64'(out_ofs), 64'd2);
    chk("R2 vld low", 64'(out_vld), 64'd0);
    chk("R2 res held", out_res, 64'hA2A3_A4A5_A6A7_B0B1);
    in_op = 2'd1;
    @(negedge clk);
    chk("R10 ofs with vld low le", 64'(out_ofs), 64'd2);

    // R8: address step then data step in the next cycle
    in_vld = 1'b1;
    in_op  = 2'd0;
    in_a   = 64'h0000_0000_0000_0100;
    in_b   = 64'h0000_0000_0000_0003;
    @(negedge clk);
    chk("R4 ofs 3", 64'(out_ofs), 64'd3);
    in_op = 2'd2;
    in_a  = 64'h0011_2233_4455_6677;
    in_b  = 64'h8899_AABB_CCDD_EEFF;
    @(negedge clk);
    chk("R8 data uses new ofs", out_res, 64'h3344_5566_7788_99AA);
    chk("R8 ofs kept", 64'(out_ofs), 64'd3);
    in_vld = 1'b0;
    @(negedge clk);

    // R1: asynchronous reset in mid run
    rst_n = 1'b0;
    #1;
    chk("R1 async ofs", 64'(out_ofs), 64'd0);
    chk("R1 async res", out_res, 64'd0);
    @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    chk("R1 ofs after second release", 64'(out_ofs), 64'd0);

    done = 1'b1;
    summary();
    $finish;
  end

endmodule